// File: doc/BRIEF.md
# Guarded Oscillator Control Register Bank

This block is the register bank for an on-chip ring oscillator. A CPU accesses it through an APB-style bus. The analog ring is outside the block. The bank turns bus writes into decoded control outputs: an oscillator enable, a ring-length select, a drive level for each of eight delay stages, and a pause (dormant) request.

None of these controls accepts a raw value. Each one changes only when it receives a specific guard code. Any other code falls back to a defined safe setting and sets a sticky error flag. Software clears that flag by writing a one to it.

The bank also does three further jobs:
- It reports three status inputs from the oscillator.
- It samples the oscillator output as a random bit.
- It holds an 8-bit down counter. The counter steps once for each oscillator tick, and software can use it for short pauses.

The tick arrives as a one-cycle enable in the bus clock domain.

The divider and phase registers are only stored and read back. They drive no output from this bank.

Top module: `osc_ctl_regs`

## Requirements
- R1: After reset, reads return the following values:
  - 0x00000aa0 at control (0x00).
  - 0 at both drive registers (0x04, 0x08).
  - 0x77616b65 at pause (0x0c).
  - 0x00000ab0 at divider (0x10).
  - 0x00000008 at phase (0x14).
  - 0 at count (0x20).
  - With all status inputs low, 0 at status (0x18).
  
  The outputs after reset are `osc_en_o`=1, `range_o`=0, all stage levels 0 and `dormant_o`=0.
- R2: The enable code sits in control bits 23:12. The value 0xd1e drives `osc_en_o` low and 0xfab drives it high. Any other value drives it high and counts as a bad write.
- R3: The ring-length code sits in control bits 11:0. The codes map onto `range_o` as follows:
  - 0xfa4 gives 0 (eight stages).
  - 0xfa5 gives 1 (six stages).
  - 0xfa7 gives 2 (four stages).
  - 0xfa6 gives 3 (two stages).
  
  Any other code gives 0 and counts as a bad write.
- R4: Each drive register holds four 3-bit fields, at bits 2:0, 6:4, 10:8 and 14:12. Register 0x04 feeds stages 0–3 and register 0x08 feeds stages 4–7. Stage k's level appears on `stage_lvl_o[2k+1:2k]` and equals the number of set bits in its field. The levels apply only while bits 31:16 of the register hold 0x9696. Any other value there forces that register's four levels to 0 and counts as a bad write.
- R5: The pause register holds 32 bits. The value 0x636f6d61 raises `dormant_o`. The value 0x77616b65 lowers it. Any other value also lowers it and counts as a bad write.
- R6: Status bit 24 is the bad-write flag. It is set at the clock edge that completes a bad write and stays set through later valid writes. Writing status with bit 24 at 0 leaves the flag unchanged. Writing status with bit 24 at 1 clears it.
- R7: Status bit 31 reads `osc_stable_i`, bit 16 reads `div_running_i`, and bit 12 reads `osc_enabled_i`. Bit 0 at 0x1c reads `osc_out_i` as registered on the previous clock.
- R8: Writing the count register loads bits 7:0. Each cycle with `osc_tick_i` high decrements a nonzero count by one. A count of 0 holds at 0.
- R9: Reads return the stored raw values with unimplemented bits at zero. The implemented bits are:
  - Control: 23:0.
  - Drive registers: the mask 0xffff7777.
  - Pause: all 32 bits.
  - Divider and phase: 11:0.
  - Count: 7:0.
  
  Any address above 0x20 reads 0, and writes to such an address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bank selected |
| penable | input | 1 | Access phase of the transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address, word aligned |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| osc_stable_i | input | 1 | Oscillator running and stable |
| osc_enabled_i | input | 1 | Oscillator enabled |
| div_running_i | input | 1 | Post-divider running |
| osc_out_i | input | 1 | Raw oscillator output, sampled for the random bit |
| osc_tick_i | input | 1 | One-cycle oscillator tick that steps the counter |
| osc_en_o | output | 1 | Oscillator enable |
| range_o | output | 2 | Ring-length select (0 low … 3 too-high) |
| stage_lvl_o | output | NUM_STAGES*2 | 2-bit drive level for each stage |
| dormant_o | output | 1 | Pause request |

## Verification
The hardest case to reach is a bad-write flag that must stay set across later traffic. The bench provokes the flag with each kind of invalid code: an enable code, a range code, a drive key and a pause word. It then writes a valid code and a status word with bit 24 at zero, and confirms the flag is still set before the one-to-clear write removes it. The counter's hold at zero is reached by driving the tick input for more cycles than the loaded count. The count is read back only while the tick is held low, so each read sees a settled value.

// File: rtl/osc_ctl_pkg.sv
package osc_ctl_pkg;

  localparam int unsigned REG_W = 32;

  // Word indices (byte offset / 4)
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_DRV0  = 1;
  localparam int unsigned IDX_PAUSE = 3;
  localparam int unsigned IDX_DIV   = 4;
  localparam int unsigned IDX_PHASE = 5;
  localparam int unsigned IDX_STAT  = 6;
  localparam int unsigned IDX_RAND  = 7;
  localparam int unsigned IDX_CNT   = 8;

  localparam logic [11:0] EN_OFF_CODE = 12'hd1e;
  localparam logic [11:0] EN_ON_CODE  = 12'hfab;
  localparam logic [11:0] RNG_LOW_CODE  = 12'hfa4;
  localparam logic [11:0] RNG_MED_CODE  = 12'hfa5;
  localparam logic [11:0] RNG_HIGH_CODE = 12'hfa7;
  localparam logic [11:0] RNG_TOP_CODE  = 12'hfa6;
  localparam logic [15:0] DRV_KEY       = 16'h9696;
  localparam logic [31:0] PAUSE_SLEEP   = 32'h636f6d61;
  localparam logic [31:0] PAUSE_RUN     = 32'h77616b65;

  localparam logic [31:0] CTRL_RST  = 32'h0000_0aa0;
  localparam logic [31:0] CTRL_MASK = 32'h00ff_ffff;
  localparam logic [11:0] DIV_RST   = 12'hab0;
  localparam logic [11:0] PHASE_RST = 12'h008;
  localparam int unsigned BAD_BIT   = 24;

  typedef enum logic [1:0] {
    RNG_LOW     = 2'd0,
    RNG_MED     = 2'd1,
    RNG_HIGH    = 2'd2,
    RNG_TOOHIGH = 2'd3
  } rng_e;

  function automatic logic range_known(input logic [11:0] code);
    return (code == RNG_LOW_CODE) || (code == RNG_MED_CODE) ||
           (code == RNG_HIGH_CODE) || (code == RNG_TOP_CODE);
  endfunction

  function automatic rng_e range_decode(input logic [11:0] code);
    case (code)
      RNG_MED_CODE:  return RNG_MED;
      RNG_HIGH_CODE: return RNG_HIGH;
      RNG_TOP_CODE:  return RNG_TOOHIGH;
      default:       return RNG_LOW;
    endcase
  endfunction

endpackage

// File: rtl/osc_ctl_wrcheck.sv
module osc_ctl_wrcheck
  import osc_ctl_pkg::*;
#(
  parameter int NUM_DRV = 2
) (
  input  logic               wr_ctrl_i,
  input  logic [NUM_DRV-1:0] wr_drv_i,
  input  logic               wr_pause_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic               bad_o
);

  logic en_ok;
  logic key_ok;
  logic pause_ok;

  assign en_ok    = (wdata_i[23:12] == EN_OFF_CODE) || (wdata_i[23:12] == EN_ON_CODE);
  assign key_ok   = (wdata_i[31:16] == DRV_KEY);
  assign pause_ok = (wdata_i == PAUSE_SLEEP) || (wdata_i == PAUSE_RUN);

  assign bad_o = (wr_ctrl_i && !(en_ok && range_known(wdata_i[11:0]))) ||
                 ((|wr_drv_i) && !key_ok) ||
                 (wr_pause_i && !pause_ok);

endmodule

// File: rtl/osc_ctl_drive_dec.sv
module osc_ctl_drive_dec
  import osc_ctl_pkg::*;
#(
  parameter int FIELDS = 4,
  parameter int DS_W   = 3,
  parameter int PITCH  = 4,
  parameter int LVL_W  = 2
) (
  input  logic [REG_W-1:0]        reg_i,
  output logic [FIELDS*LVL_W-1:0] lvl_o
);

  logic key_ok;
  assign key_ok = (reg_i[REG_W-1:16] == DRV_KEY);

  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign lvl_o[f*LVL_W +: LVL_W] =
      key_ok ? LVL_W'($countones(reg_i[f*PITCH +: DS_W])) : '0;
  end

endmodule

// File: rtl/osc_ctl_downcnt.sv
module osc_ctl_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/osc_ctl_regs.sv
module osc_ctl_regs
  import osc_ctl_pkg::*;
#(
  parameter  int ADDR_W         = 6,
  parameter  int CNT_W          = 8,
  parameter  int NUM_STAGES     = 8,
  parameter  int STAGES_PER_REG = 4,
  parameter  int DS_W           = 3,
  localparam int LVL_W          = $clog2(DS_W + 1)
) (
  input  logic                        pclk,
  input  logic                        presetn,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  input  logic                        osc_stable_i,
  input  logic                        osc_enabled_i,
  input  logic                        div_running_i,
  input  logic                        osc_out_i,
  input  logic                        osc_tick_i,
  output logic                        osc_en_o,
  output logic [1:0]                  range_o,
  output logic [NUM_STAGES*LVL_W-1:0] stage_lvl_o,
  output logic                        dormant_o
);

  localparam int IDX_W    = ADDR_W - 2;
  localparam int NUM_DRV  = NUM_STAGES / STAGES_PER_REG;
  localparam int PITCH    = DS_W + 1;
  localparam int LANE_W   = STAGES_PER_REG * LVL_W;

  function automatic logic [REG_W-1:0] drv_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[REG_W-1:16] = '1;
    for (int f = 0; f < STAGES_PER_REG; f++) m[f*PITCH +: DS_W] = '1;
    return m;
  endfunction
  localparam logic [REG_W-1:0] DRV_MASK = drv_mask();

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_pipe <= '0;
    else          rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n = rst_pipe[1];

  // Address decode
  logic [IDX_W-1:0]   widx;
  logic               wr_en;
  logic               sel_ctrl, sel_pause, sel_div, sel_phase, sel_stat, sel_rand, sel_cnt;
  logic [NUM_DRV-1:0] sel_drv;

  assign widx      = paddr[ADDR_W-1:2];
  assign wr_en     = psel && penable && pwrite;
  assign sel_ctrl  = (widx == IDX_W'(IDX_CTRL));
  assign sel_pause = (widx == IDX_W'(IDX_PAUSE));
  assign sel_div   = (widx == IDX_W'(IDX_DIV));
  assign sel_phase = (widx == IDX_W'(IDX_PHASE));
  assign sel_stat  = (widx == IDX_W'(IDX_STAT));
  assign sel_rand  = (widx == IDX_W'(IDX_RAND));
  assign sel_cnt   = (widx == IDX_W'(IDX_CNT));
  for (genvar r = 0; r < NUM_DRV; r++) begin : g_sel
    assign sel_drv[r] = (widx == IDX_W'(IDX_DRV0 + r));
  end

  // Storage
  logic [REG_W-1:0] ctrl_q, ctrl_d;
  logic [REG_W-1:0] pause_q, pause_d;
  logic [11:0]      div_q, div_d;
  logic [11:0]      phase_q, phase_d;
  logic [REG_W-1:0] drv_q [NUM_DRV];
  logic [REG_W-1:0] drv_d [NUM_DRV];
  logic             bad_q, bad_d;
  logic             rnd_q;
  logic             bad_set;
  logic             bad_clr;
  logic [CNT_W-1:0] cnt_val;

  osc_ctl_wrcheck #(.NUM_DRV(NUM_DRV)) u_wrchk (
    .wr_ctrl_i  (wr_en && sel_ctrl),
    .wr_drv_i   (wr_en ? sel_drv : '0),
    .wr_pause_i (wr_en && sel_pause),
    .wdata_i    (pwdata),
    .bad_o      (bad_set)
  );

  assign bad_clr = wr_en && sel_stat && pwdata[BAD_BIT];

  always_comb begin
    ctrl_d  = ctrl_q;
    pause_d = pause_q;
    div_d   = div_q;
    phase_d = phase_q;
    for (int r = 0; r < NUM_DRV; r++) drv_d[r] = drv_q[r];
    if (wr_en) begin
      if (sel_ctrl)  ctrl_d  = pwdata & CTRL_MASK;
      if (sel_pause) pause_d = pwdata;
      if (sel_div)   div_d   = pwdata[11:0];
      if (sel_phase) phase_d = pwdata[11:0];
      for (int r = 0; r < NUM_DRV; r++) begin
        if (sel_drv[r]) drv_d[r] = pwdata & DRV_MASK;
      end
    end
    // set takes priority over clear
    bad_d = (bad_q && !bad_clr) || bad_set;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      pause_q <= PAUSE_RUN;
      div_q   <= DIV_RST;
      phase_q <= PHASE_RST;
      bad_q   <= 1'b0;
      rnd_q   <= 1'b0;
      for (int r = 0; r < NUM_DRV; r++) drv_q[r] <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pause_q <= pause_d;
      div_q   <= div_d;
      phase_q <= phase_d;
      bad_q   <= bad_d;
      rnd_q   <= osc_out_i;
      for (int r = 0; r < NUM_DRV; r++) drv_q[r] <= drv_d[r];
    end
  end

  osc_ctl_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (pclk),
    .rst_n      (rst_n),
    .load_i     (wr_en && sel_cnt),
    .load_val_i (pwdata[CNT_W-1:0]),
    .tick_i     (osc_tick_i),
    .cnt_o      (cnt_val)
  );

  // Decoded controls
  assign osc_en_o  = (ctrl_q[23:12] != EN_OFF_CODE);
  assign range_o   = range_decode(ctrl_q[11:0]);
  assign dormant_o = (pause_q == PAUSE_SLEEP);

  for (genvar r = 0; r < NUM_DRV; r++) begin : g_drv
    osc_ctl_drive_dec #(
      .FIELDS (STAGES_PER_REG),
      .DS_W   (DS_W),
      .PITCH  (PITCH),
      .LVL_W  (LVL_W)
    ) u_dec (
      .reg_i (drv_q[r]),
      .lvl_o (stage_lvl_o[r*LANE_W +: LANE_W])
    );
  end

  // Read mux
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl)  rd_mux = ctrl_q;
    if (sel_pause) rd_mux = pause_q;
    if (sel_div)   rd_mux = {20'b0, div_q};
    if (sel_phase) rd_mux = {20'b0, phase_q};
    if (sel_stat)  rd_mux = {osc_stable_i, 6'b0, bad_q, 7'b0, div_running_i,
                             3'b0, osc_enabled_i, 12'b0};
    if (sel_rand)  rd_mux = {31'b0, rnd_q};
    if (sel_cnt)   rd_mux = 32'(cnt_val);
    for (int r = 0; r < NUM_DRV; r++) begin
      if (sel_drv[r]) rd_mux = drv_q[r];
    end
  end

  assign prdata = psel ? rd_mux : '0;

endmodule

// File: rtl/osc_ctl_regs_chk.sv
module osc_ctl_regs_chk #(
  parameter int ADDR_W         = 6,
  parameter int CNT_W          = 8,
  parameter int NUM_STAGES     = 8,
  parameter int STAGES_PER_REG = 4,
  parameter int LVL_W          = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        psel,
  input logic                        penable,
  input logic                        pwrite,
  input logic [ADDR_W-1:0]           paddr,
  input logic [31:0]                 pwdata,
  input logic                        osc_en_o,
  input logic                        dormant_o,
  input logic [NUM_STAGES*LVL_W-1:0] stage_lvl_o,
  input logic                        bad_q,
  input logic [CNT_W-1:0]            cnt_val,
  input logic                        osc_tick_i
);

  localparam int IDX_W = ADDR_W - 2;
  logic             wr;
  logic [IDX_W-1:0] idx;
  assign wr  = psel && penable && pwrite;
  assign idx = paddr[ADDR_W-1:2];

  a_r2_disable_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(0) && pwdata[23:12] == 12'hd1e) |=> !osc_en_o);

  a_r2_enable_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(0) && pwdata[23:12] != 12'hd1e) |=> osc_en_o);

  a_r4_key_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(1) && pwdata[31:16] != 16'h9696)
      |=> (stage_lvl_o[STAGES_PER_REG*LVL_W-1:0] == '0));

  a_r5_pause_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(3)) |=> (dormant_o == ($past(pwdata) == 32'h636f6d61)));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_q && !(wr && idx == IDX_W'(6) && pwdata[24])) |=> bad_q);

  a_r6_pause_bad_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == IDX_W'(3) && pwdata != 32'h636f6d61 && pwdata != 32'h77616b65) |=> bad_q);

  a_r8_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val == '0 && !(wr && idx == IDX_W'(8))) |=> (cnt_val == '0));

  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_val != '0 && osc_tick_i && !(wr && idx == IDX_W'(8)))
      |=> (cnt_val == $past(cnt_val) - CNT_W'(1)));

endmodule

bind osc_ctl_regs osc_ctl_regs_chk #(
  .ADDR_W         (ADDR_W),
  .CNT_W          (CNT_W),
  .NUM_STAGES     (NUM_STAGES),
  .STAGES_PER_REG (STAGES_PER_REG),
  .LVL_W          (LVL_W)
) u_chk (
  .clk         (pclk),
  .rst_n       (rst_n),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .osc_en_o    (osc_en_o),
  .dormant_o   (dormant_o),
  .stage_lvl_o (stage_lvl_o),
  .bad_q       (bad_q),
  .cnt_val     (cnt_val),
  .osc_tick_i  (osc_tick_i)
);

// File: tb/osc_ctl_regs_tb.sv
`timescale 1ns/1ps
module osc_ctl_regs_tb;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [5:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        osc_stable_i, osc_enabled_i, div_running_i, osc_out_i, osc_tick_i;
  logic        osc_en_o, dormant_o;
  logic [1:0]  range_o;
  logic [15:0] stage_lvl_o;

  int checks = 0;
  int errors = 0;

  always #2 pclk = ~pclk;

  osc_ctl_regs u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .osc_stable_i(osc_stable_i), .osc_enabled_i(osc_enabled_i),
    .div_running_i(div_running_i), .osc_out_i(osc_out_i), .osc_tick_i(osc_tick_i),
    .osc_en_o(osc_en_o), .range_o(range_o), .stage_lvl_o(stage_lvl_o),
    .dormant_o(dormant_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge pclk);
    penable = 1'b1;
    #1 chk(req, prdata, exp);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic flag_chk(input string req, input logic exp);
    rd_chk(req, 6'h18, {7'b0, exp, 24'b0});
  endtask

  task automatic t_reset;
    rd_chk("R1 ctrl reset", 6'h00, 32'h0000_0aa0);
    rd_chk("R1 drive0 reset", 6'h04, 32'h0);
    rd_chk("R1 drive1 reset", 6'h08, 32'h0);
    rd_chk("R1 pause reset", 6'h0c, 32'h7761_6b65);
    rd_chk("R1 div reset", 6'h10, 32'h0000_0ab0);
    rd_chk("R1 phase reset", 6'h14, 32'h0000_0008);
    rd_chk("R1 status reset", 6'h18, 32'h0);
    rd_chk("R1 count reset", 6'h20, 32'h0);
    chk("R1 outputs reset", {12'b0, osc_en_o, range_o, dormant_o, stage_lvl_o},
        {12'b0, 1'b1, 2'd0, 1'b0, 16'h0});
  endtask

  task automatic t_enable_range;
    wr(6'h00, 32'h00fa_bfa7);
    chk("R3 high code", {30'b0, range_o}, 32'd2);
    chk("R2 enable code", {31'b0, osc_en_o}, 32'd1);
    wr(6'h00, 32'h00fa_bfa6);
    chk("R3 too-high code", {30'b0, range_o}, 32'd3);
    wr(6'h00, 32'h00d1_efa5);
    chk("R3 medium code", {30'b0, range_o}, 32'd1);
    chk("R2 disable code", {31'b0, osc_en_o}, 32'd0);
    flag_chk("R2 valid codes leave flag clear", 1'b0);
    wr(6'h00, 32'hff12_3fa4);
    chk("R2 unknown enable code enables", {31'b0, osc_en_o}, 32'd1);
    chk("R3 low code", {30'b0, range_o}, 32'd0);
    rd_chk("R9 ctrl read masked", 6'h00, 32'h0012_3fa4);
    flag_chk("R2 unknown enable code flagged", 1'b1);
    wr(6'h18, 32'h0100_0000);
    wr(6'h00, 32'h00fa_b123);
    chk("R3 unknown range falls to low", {30'b0, range_o}, 32'd0);
    flag_chk("R3 unknown range flagged", 1'b1);
    wr(6'h18, 32'h0100_0000);
  endtask

  task automatic t_drive;
    wr(6'h04, 32'h9696_7531);
    chk("R4 stages 0-3 levels", {16'b0, stage_lvl_o}, 32'h0000_00e9);
    rd_chk("R9 drive0 readback", 6'h04, 32'h9696_7531);
    wr(6'h08, 32'h9696_ffff);
    chk("R4 stages 4-7 levels", {16'b0, stage_lvl_o}, 32'h0000_ffe9);
    rd_chk("R9 drive1 read masked", 6'h08, 32'h9696_7777);
    flag_chk("R4 valid key leaves flag clear", 1'b0);
    wr(6'h04, 32'h1234_7777);
    chk("R4 wrong key zeroes lane", {16'b0, stage_lvl_o}, 32'h0000_ff00);
    rd_chk("R4 wrong key still stored", 6'h04, 32'h1234_7777);
    flag_chk("R4 wrong key flagged", 1'b1);
    wr(6'h18, 32'h0100_0000);
  endtask

  task automatic t_pause;
    wr(6'h0c, 32'h636f_6d61);
    chk("R5 dormant code", {31'b0, dormant_o}, 32'd1);
    flag_chk("R5 dormant code not flagged", 1'b0);
    wr(6'h0c, 32'hdead_beef);
    chk("R5 unknown word wakes", {31'b0, dormant_o}, 32'd0);
    flag_chk("R5 unknown word flagged", 1'b1);
    wr(6'h18, 32'h0100_0000);
    wr(6'h0c, 32'h636f_6d61);
    wr(6'h0c, 32'h7761_6b65);
    chk("R5 wake code", {31'b0, dormant_o}, 32'd0);
    flag_chk("R5 wake code not flagged", 1'b0);
  endtask

  task automatic t_flag;
    wr(6'h0c, 32'h0000_0001);
    wr(6'h0c, 32'h7761_6b65);
    flag_chk("R6 flag survives valid write", 1'b1);
    wr(6'h18, 32'hfeff_ffff);
    flag_chk("R6 write of zero bit keeps flag", 1'b1);
    wr(6'h18, 32'h0100_0000);
    flag_chk("R6 write one clears flag", 1'b0);
  endtask

  task automatic t_status_rand;
    osc_stable_i = 1'b1; osc_enabled_i = 1'b0; div_running_i = 1'b1;
    rd_chk("R7 status stable+div", 6'h18, 32'h8001_0000);
    osc_stable_i = 1'b0; osc_enabled_i = 1'b1; div_running_i = 1'b0;
    rd_chk("R7 status enabled", 6'h18, 32'h0000_1000);
    osc_out_i = 1'b1;
    rd_chk("R7 random bit high", 6'h1c, 32'h1);
    osc_out_i = 1'b0;
    rd_chk("R7 random bit low", 6'h1c, 32'h0);
  endtask

  task automatic t_counter;
    wr(6'h20, 32'h0000_0105);
    rd_chk("R8 load masked to 8 bits", 6'h20, 32'h5);
    @(negedge pclk); osc_tick_i = 1'b1;
    repeat (3) @(negedge pclk);
    osc_tick_i = 1'b0;
    rd_chk("R8 three ticks", 6'h20, 32'h2);
    rd_chk("R8 no tick no change", 6'h20, 32'h2);
    @(negedge pclk); osc_tick_i = 1'b1;
    repeat (10) @(negedge pclk);
    osc_tick_i = 1'b0;
    rd_chk("R8 holds at zero", 6'h20, 32'h0);
  endtask

  task automatic t_map;
    wr(6'h10, 32'hffff_f123);
    rd_chk("R9 div read masked", 6'h10, 32'h0000_0123);
    wr(6'h14, 32'h0000_0aa5);
    rd_chk("R9 phase readback", 6'h14, 32'h0000_0aa5);
    wr(6'h00, 32'h00fa_bfa5);
    wr(6'h24, 32'hffff_ffff);
    rd_chk("R9 unmapped reads zero", 6'h24, 32'h0);
    rd_chk("R9 unmapped write ignored", 6'h00, 32'h00fa_bfa5);
    rd_chk("R9 high unmapped reads zero", 6'h3c, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge pclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0;
    osc_stable_i = 1'b0; osc_enabled_i = 1'b0; div_running_i = 1'b0;
    osc_out_i = 1'b0; osc_tick_i = 1'b0;
    repeat (4) @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);
    t_reset();
    t_enable_range();
    t_drive();
    t_pause();
    t_flag();
    t_status_rand();
    t_counter();
    t_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule